// File: doc/BRIEF.md
# Software Trap and Return Controller

This block sits beside the fetch stage of a small 32-bit core and owns the exception-state registers. When the core executes a software trap it presents a single-cycle request with a 5-bit vector and the PC of the trap instruction. The block then saves the return PC and the processor status word, records a cause code and raises the in-exception and interrupt-disable flags. It also hands fetch a new PC together with a one-cycle redirect strobe.

A return request restores PC and status word from one of two save banks. The ordinary bank is used for normal exceptions. The fatal bank is used only when the status word shows a fatal exception in progress and no ordinary one. The highest vector is reserved for an operating-system call path: it raises only a one-cycle bypass pulse and changes no state.

All exception registers can be read and written through a simple register port, so that handlers can inspect and patch them.

Top module: `trap_return_ctrl`

## Requirements
- R1: After reset the status word, the cause register, both saved PCs, both saved status words, `redirect` and `osCallHit` are all zero.
- R2: A trap with a vector from 0 to 30 raises `redirect` for exactly one cycle after the request edge. `nextPc` is 0x40 for vectors 0 to 15 and 0x50 for vectors 16 to 30.
- R3: On such a trap, the ordinary saved PC becomes the request PC plus 4 (modulo 2^32) and the ordinary saved status word becomes the status word from before the trap.
- R4: On such a trap, the low 16 bits of the cause register become 0x40 plus the vector and the upper 16 bits keep their value.
- R5: On such a trap, status-word bit 6 (in-exception) and bit 5 (interrupt-disable) are set and all other bits keep their value.
- R6: A trap with vector 31 raises `osCallHit` for one cycle. It raises no `redirect` and leaves `nextPc`, the status word, the saved registers and the cause register unchanged.
- R7: A return while status bit 7 (fatal-pending) is 1 and bit 6 is 0 loads `nextPc` from the fatal saved PC and the status word from the fatal saved status word, with a one-cycle `redirect`.
- R8: A return in any other status state loads `nextPc` and the status word from the ordinary saved PC and saved status word, with a one-cycle `redirect`.
- R9: When a trap and a return are requested in the same cycle, only the trap is performed.
- R10: Register port selects: 0 ordinary saved PC, 1 ordinary saved status, 2 fatal saved PC, 3 fatal saved status, 4 cause, 5 status word. Reads are combinational. A write takes effect at the request edge.
- R11: A port write in the same cycle as a trap, to a register the trap updates, is discarded in favour of the trap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Software trap request, one-cycle pulse |
| trapVec | input | 5 | Trap vector number |
| curPc | input | 32 | PC of the trap instruction |
| retReq | input | 1 | Exception return request, one-cycle pulse |
| csrWrEn | input | 1 | Register port write enable |
| csrWrSel | input | 3 | Register port write select |
| csrWrData | input | 32 | Register port write data |
| csrRdSel | input | 3 | Register port read select |
| csrRdData | output | 32 | Register port read data |
| nextPc | output | 32 | Redirect target PC |
| redirect | output | 1 | One-cycle strobe, `nextPc` valid |
| osCallHit | output | 1 | One-cycle pulse for a vector-31 trap |

## Verification
Every result of a trap or return is registered, so `redirect`, `osCallHit`, `nextPc` and the updated registers all appear after the single clock edge that samples the request. Register-port reads are combinational and reflect that edge at once. The bench drives each request on a falling edge and removes it on the next falling edge, where it samples the outputs. It then steps the read select through the registers, with a short settle delay, before the next rising edge. A second sample one cycle later confirms that the strobe has already fallen.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

  localparam int PSW_ID_BIT = 5;
  localparam int PSW_EP_BIT = 6;
  localparam int PSW_NP_BIT = 7;

  localparam int LOW_ENTRY  = 32'h40;
  localparam int HIGH_ENTRY = 32'h50;
  localparam int CAUSE_BASE = 32'h40;

  typedef enum logic [2:0] {
    SEL_EXC_PC  = 3'd0,
    SEL_EXC_PSW = 3'd1,
    SEL_FAT_PC  = 3'd2,
    SEL_FAT_PSW = 3'd3,
    SEL_CAUSE   = 3'd4,
    SEL_PSW     = 3'd5
  } csrSel_e;

  typedef struct packed {
    logic takeTrap;
    logic takeRet;
    logic retFatal;
    logic osCall;
    logic highVec;
  } ctlStrobe_t;

endpackage

// File: rtl/trap_ret_ctl.sv
module trap_ret_ctl
  import trap_ret_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic             trapReq,
  input  logic [VEC_W-1:0] trapVec,
  input  logic             retReq,
  input  logic             pswNp,
  input  logic             pswEp,
  output ctlStrobe_t       strobe
);

  logic isBypassVec;

  // The all-ones vector is the OS-call path.
  assign isBypassVec = (trapVec == {VEC_W{1'b1}});

  always_comb begin
    strobe.takeTrap = trapReq && !isBypassVec;
    strobe.osCall   = trapReq && isBypassVec;
    // Trap has priority over return in the same cycle.
    strobe.takeRet  = retReq && !trapReq;
    strobe.retFatal = pswNp && !pswEp;
    strobe.highVec  = trapVec[VEC_W-1];
  end

endmodule

// File: rtl/trap_ret_bank.sv
module trap_ret_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapLoad,
  input  logic [XLEN-1:0] trapPc,
  input  logic [XLEN-1:0] trapPsw,
  input  logic            wrPc,
  input  logic            wrPsw,
  input  logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] pcQ,
  output logic [XLEN-1:0] pswQ
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= '0;
      pswQ <= '0;
    end else if (trapLoad) begin
      pcQ  <= trapPc;
      pswQ <= trapPsw;
    end else begin
      if (wrPc)  pcQ  <= wrData;
      if (wrPsw) pswQ <= wrData;
    end
  end

endmodule

// File: rtl/trap_ret_dpath.sv
module trap_ret_dpath
  import trap_ret_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [VEC_W-1:0] trapVec,
  input  logic [XLEN-1:0]  curPc,
  input  logic             csrWrEn,
  input  logic [2:0]       csrWrSel,
  input  logic [XLEN-1:0]  csrWrData,
  input  logic [2:0]       csrRdSel,
  output logic [XLEN-1:0]  csrRdData,
  output logic [XLEN-1:0]  nextPc,
  output logic             redirect,
  output logic             osCallHit,
  output logic [XLEN-1:0]  pswQ,
  output logic [XLEN-1:0]  excPcQ,
  output logic [XLEN-1:0]  excPswQ,
  output logic [XLEN-1:0]  fatPcQ,
  output logic [XLEN-1:0]  causeQ
);

  localparam int HALF = XLEN / 2;
  localparam int NUM_BANKS = 2;
  localparam logic [XLEN-1:0] PSW_SET_MASK =
    (XLEN'(1) << PSW_EP_BIT) | (XLEN'(1) << PSW_ID_BIT);

  logic [XLEN-1:0] bankPc  [NUM_BANKS];
  logic [XLEN-1:0] bankPsw [NUM_BANKS];
  logic [XLEN-1:0] returnPc;
  logic [HALF-1:0] causeCode;
  logic [XLEN-1:0] fatPswQ;

  // Bank 0 holds ordinary exception state and is loaded by a trap;
  // bank 1 holds fatal exception state and is written only by software.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [2:0] PC_SEL  = (b == 0) ? 3'd0 : 3'd2;
    localparam logic [2:0] PSW_SEL = PC_SEL + 3'd1;
    logic loadHere;
    assign loadHere = (b == 0) ? strobe.takeTrap : 1'b0;
    trap_ret_bank #(.XLEN(XLEN)) u_bank (
      .clk      (clk),
      .rstN     (rstN),
      .trapLoad (loadHere),
      .trapPc   (curPc + XLEN'(4)),
      .trapPsw  (pswQ),
      .wrPc     (csrWrEn && (csrWrSel == PC_SEL)),
      .wrPsw    (csrWrEn && (csrWrSel == PSW_SEL)),
      .wrData   (csrWrData),
      .pcQ      (bankPc[b]),
      .pswQ     (bankPsw[b])
    );
  end

  assign excPcQ  = bankPc[0];
  assign excPswQ = bankPsw[0];
  assign fatPcQ  = bankPc[1];
  assign fatPswQ = bankPsw[1];

  assign causeCode = HALF'(CAUSE_BASE) + HALF'(trapVec);
  assign returnPc  = strobe.retFatal ? fatPcQ : excPcQ;

  // Status word: trap sets flags, return restores, else software write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pswQ <= '0;
    end else if (strobe.takeTrap) begin
      pswQ <= pswQ | PSW_SET_MASK;
    end else if (strobe.takeRet) begin
      pswQ <= strobe.retFatal ? fatPswQ : excPswQ;
    end else if (csrWrEn && (csrWrSel == SEL_PSW)) begin
      pswQ <= csrWrData;
    end
  end

  // Cause: trap merges its code into the low half only.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ <= '0;
    end else if (strobe.takeTrap) begin
      causeQ <= {causeQ[XLEN-1:HALF], causeCode};
    end else if (csrWrEn && (csrWrSel == SEL_CAUSE)) begin
      causeQ <= csrWrData;
    end
  end

  // Redirect target and strobes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextPc    <= '0;
      redirect  <= 1'b0;
      osCallHit <= 1'b0;
    end else begin
      redirect  <= strobe.takeTrap || strobe.takeRet;
      osCallHit <= strobe.osCall;
      if (strobe.takeTrap) begin
        nextPc <= strobe.highVec ? XLEN'(HIGH_ENTRY) : XLEN'(LOW_ENTRY);
      end else if (strobe.takeRet) begin
        nextPc <= returnPc;
      end
    end
  end

  always_comb begin
    unique case (csrRdSel)
      SEL_EXC_PC:  csrRdData = excPcQ;
      SEL_EXC_PSW: csrRdData = excPswQ;
      SEL_FAT_PC:  csrRdData = fatPcQ;
      SEL_FAT_PSW: csrRdData = fatPswQ;
      SEL_CAUSE:   csrRdData = causeQ;
      SEL_PSW:     csrRdData = pswQ;
      default:     csrRdData = '0;
    endcase
  end

endmodule

// File: rtl/trap_return_ctrl.sv
module trap_return_ctrl
  import trap_ret_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapReq,
  input  logic [VEC_W-1:0] trapVec,
  input  logic [XLEN-1:0]  curPc,
  input  logic             retReq,
  input  logic             csrWrEn,
  input  logic [2:0]       csrWrSel,
  input  logic [XLEN-1:0]  csrWrData,
  input  logic [2:0]       csrRdSel,
  output logic [XLEN-1:0]  csrRdData,
  output logic [XLEN-1:0]  nextPc,
  output logic             redirect,
  output logic             osCallHit
);

  ctlStrobe_t      strobe;
  logic [XLEN-1:0] pswQ;
  logic [XLEN-1:0] excPcQ;
  logic [XLEN-1:0] excPswQ;
  logic [XLEN-1:0] fatPcQ;
  logic [XLEN-1:0] causeQ;

  trap_ret_ctl #(.VEC_W(VEC_W)) u_ctl (
    .trapReq (trapReq),
    .trapVec (trapVec),
    .retReq  (retReq),
    .pswNp   (pswQ[PSW_NP_BIT]),
    .pswEp   (pswQ[PSW_EP_BIT]),
    .strobe  (strobe)
  );

  trap_ret_dpath #(.XLEN(XLEN), .VEC_W(VEC_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .trapVec   (trapVec),
    .curPc     (curPc),
    .csrWrEn   (csrWrEn),
    .csrWrSel  (csrWrSel),
    .csrWrData (csrWrData),
    .csrRdSel  (csrRdSel),
    .csrRdData (csrRdData),
    .nextPc    (nextPc),
    .redirect  (redirect),
    .osCallHit (osCallHit),
    .pswQ      (pswQ),
    .excPcQ    (excPcQ),
    .excPswQ   (excPswQ),
    .fatPcQ    (fatPcQ),
    .causeQ    (causeQ)
  );

endmodule

// File: rtl/trap_ret_checker.sv
module trap_ret_checker #(
  parameter int XLEN  = 32,
  parameter int VEC_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             trapReq,
  input logic [VEC_W-1:0] trapVec,
  input logic [XLEN-1:0]  curPc,
  input logic             retReq,
  input logic             csrWrEn,
  input logic [2:0]       csrWrSel,
  input logic [XLEN-1:0]  nextPc,
  input logic             redirect,
  input logic             osCallHit,
  input logic [XLEN-1:0]  pswQ,
  input logic [XLEN-1:0]  excPcQ,
  input logic [XLEN-1:0]  excPswQ,
  input logic [XLEN-1:0]  fatPcQ,
  input logic [XLEN-1:0]  causeQ
);

  localparam logic [VEC_W-1:0] BYP = {VEC_W{1'b1}};
  localparam logic [XLEN-1:0] FLAGS = XLEN'(32'h60);

  logic normTrap;
  assign normTrap = trapReq && (trapVec != BYP);

  AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    normTrap |=> redirect && (nextPc == ($past(trapVec[VEC_W-1]) ? XLEN'(32'h50) : XLEN'(32'h40)))); // R2

  AST_TRAP_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    normTrap |=> (excPcQ == $past(curPc) + XLEN'(4)) && (excPswQ == $past(pswQ))); // R3

  AST_CAUSE_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    normTrap |=> (causeQ[15:0] == 16'h40 + 16'($past(trapVec))) && (causeQ[XLEN-1:16] == $past(causeQ[XLEN-1:16]))); // R4

  AST_PSW_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    normTrap |=> ((pswQ & FLAGS) == FLAGS) && ((pswQ | FLAGS) == ($past(pswQ) | FLAGS))); // R5

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && (trapVec == BYP) && !(csrWrEn && csrWrSel == 3'd5)) |=> osCallHit && !redirect && $stable(pswQ) && $stable(nextPc)); // R6

  AST_RET_FATAL: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !trapReq && pswQ[7] && !pswQ[6]) |=> redirect && (nextPc == $past(fatPcQ))); // R7

  AST_RET_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (retReq && !trapReq && !(pswQ[7] && !pswQ[6])) |=> redirect && (nextPc == $past(excPcQ)) && (pswQ == $past(excPswQ))); // R8

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!trapReq && !retReq) |=> !redirect && !osCallHit); // R2

endmodule

bind trap_return_ctrl trap_ret_checker #(.XLEN(XLEN), .VEC_W(VEC_W)) chk_i (.*);

// File: tb/trap_return_ctrl_tb_top.sv
module trap_return_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic [4:0]  trapVec = '0;
  logic [31:0] curPc = '0;
  logic        retReq = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [2:0]  csrWrSel = '0;
  logic [31:0] csrWrData = '0;
  logic [2:0]  csrRdSel = '0;
  logic [31:0] csrRdData;
  logic [31:0] nextPc;
  logic        redirect;
  logic        osCallHit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trap_return_ctrl dut_i (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapVec(trapVec),
    .curPc(curPc), .retReq(retReq), .csrWrEn(csrWrEn), .csrWrSel(csrWrSel),
    .csrWrData(csrWrData), .csrRdSel(csrRdSel), .csrRdData(csrRdData),
    .nextPc(nextPc), .redirect(redirect), .osCallHit(osCallHit)
  );

  typedef struct packed {
    logic        trap;
    logic        ret;
    logic [4:0]  vec;
    logic [31:0] pc;
    logic        expRedir;
    logic        expOs;
    logic [31:0] expNext;
    logic [31:0] expPsw;
    logic [31:0] expExcPc;
    logic [31:0] expExcPsw;
    logic [31:0] expCause;
  } vec_t;

  // Starts from status word 0x101 with all else zero.
  localparam vec_t TABLE [6] = '{
    '{1'b1, 1'b0, 5'd3,  32'h100,      1'b1, 1'b0, 32'h40,  32'h161, 32'h104, 32'h101, 32'h43},
    '{1'b1, 1'b0, 5'd20, 32'h200,      1'b1, 1'b0, 32'h50,  32'h161, 32'h204, 32'h161, 32'h54},
    '{1'b0, 1'b1, 5'd0,  32'h0,        1'b1, 1'b0, 32'h204, 32'h161, 32'h204, 32'h161, 32'h54},
    '{1'b1, 1'b0, 5'd31, 32'h400,      1'b0, 1'b1, 32'h204, 32'h161, 32'h204, 32'h161, 32'h54},
    '{1'b1, 1'b1, 5'd15, 32'h300,      1'b1, 1'b0, 32'h40,  32'h161, 32'h304, 32'h161, 32'h4F},
    '{1'b1, 1'b0, 5'd16, 32'hFFFFFFFC, 1'b1, 1'b0, 32'h50,  32'h161, 32'h0,   32'h161, 32'h50}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readCsr(input logic [2:0] sel, output logic [31:0] val);
    csrRdSel = sel;
    #1;
    val = csrRdData;
  endtask

  // Apply for one cycle from a falling edge; return at the next falling edge.
  task automatic step(input logic t, input logic r, input logic [4:0] v,
                      input logic [31:0] pc, input logic we,
                      input logic [2:0] ws, input logic [31:0] wd);
    @(negedge clk);
    trapReq = t; retReq = r; trapVec = v; curPc = pc;
    csrWrEn = we; csrWrSel = ws; csrWrData = wd;
    @(negedge clk);
    trapReq = 1'b0; retReq = 1'b0; csrWrEn = 1'b0;
  endtask

  task automatic csrWrite(input logic [2:0] ws, input logic [31:0] wd);
    step(1'b0, 1'b0, 5'd0, 32'h0, 1'b1, ws, wd);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 6; s++) begin
      readCsr(3'(s), v);
      check("R1 reg after reset", v, 32'h0);
    end
    check("R1 redirect after reset", {31'b0, redirect}, 32'h0);
    check("R1 osCallHit after reset", {31'b0, osCallHit}, 32'h0);

    // R10: write then read back the status word
    csrWrite(3'd5, 32'h101);
    readCsr(3'd5, v);
    check("R10 psw write", v, 32'h101);

    // Table: R2 R3 R4 R5 R6 R8 R9
    for (int i = 0; i < 6; i++) begin
      step(TABLE[i].trap, TABLE[i].ret, TABLE[i].vec, TABLE[i].pc, 1'b0, 3'd0, 32'h0);
      check("R2/R6/R9 redirect", {31'b0, redirect}, {31'b0, TABLE[i].expRedir});
      check("R6 osCallHit", {31'b0, osCallHit}, {31'b0, TABLE[i].expOs});
      check("R2/R8 nextPc", nextPc, TABLE[i].expNext);
      readCsr(3'd5, v); check("R5/R8 psw", v, TABLE[i].expPsw);
      readCsr(3'd0, v); check("R3 excPc", v, TABLE[i].expExcPc);
      readCsr(3'd1, v); check("R3 excPsw", v, TABLE[i].expExcPsw);
      readCsr(3'd4, v); check("R4 cause", v, TABLE[i].expCause);
    end

    // R7: fatal-bank return
    csrWrite(3'd2, 32'h2000);
    csrWrite(3'd3, 32'h3);
    csrWrite(3'd5, 32'h80);
    readCsr(3'd2, v); check("R10 fatPc write", v, 32'h2000);
    step(1'b0, 1'b1, 5'd0, 32'h0, 1'b0, 3'd0, 32'h0);
    check("R7 redirect", {31'b0, redirect}, 32'h1);
    check("R7 nextPc", nextPc, 32'h2000);
    readCsr(3'd5, v); check("R7 psw", v, 32'h3);
    @(negedge clk);
    check("R2 strobe one cycle", {31'b0, redirect}, 32'h0);

    // R8: fatal and ordinary flags both set -> ordinary bank
    csrWrite(3'd5, 32'hC0);
    step(1'b0, 1'b1, 5'd0, 32'h0, 1'b0, 3'd0, 32'h0);
    check("R8 nextPc", nextPc, 32'h0);
    readCsr(3'd5, v); check("R8 psw", v, 32'h161);

    // R4: upper half of cause preserved
    csrWrite(3'd4, 32'hABCD0000);
    step(1'b1, 1'b0, 5'd7, 32'h10, 1'b0, 3'd0, 32'h0);
    readCsr(3'd4, v); check("R4 cause upper kept", v, 32'hABCD0047);

    // R11: same-cycle writes lose to the trap
    step(1'b1, 1'b0, 5'd1, 32'h500, 1'b1, 3'd0, 32'h1234);
    readCsr(3'd0, v); check("R11 excPc trap wins", v, 32'h504);
    step(1'b1, 1'b0, 5'd2, 32'h600, 1'b1, 3'd5, 32'h0);
    readCsr(3'd5, v); check("R11 psw trap wins", v, 32'h161);

    // R6: vector 31 leaves cause alone
    step(1'b1, 1'b0, 5'd31, 32'h700, 1'b0, 3'd0, 32'h0);
    readCsr(3'd4, v); check("R6 cause unchanged", v, 32'hABCD0042);
    readCsr(3'd0, v); check("R6 excPc unchanged", v, 32'h604);

    // R1: reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readCsr(3'd4, v); check("R1 cause after re-reset", v, 32'h0);
    readCsr(3'd5, v); check("R1 psw after re-reset", v, 32'h0);
    check("R1 nextPc after re-reset", nextPc, 32'h0);

    finishRun();
  end

endmodule